// File: doc/BRIEF.md
# Receive FIFO with Threshold DMA Request

This block sits between the receive side of a serial audio port and a DMA engine. Each word from the pins is pushed into a 64-word first-in first-out store, and the DMA engine pops words from the other end. The block does not wait for the store to fill. It asks for service with a level-sensitive request each time a programmed batch of words is ready to be moved.

Completed batches are counted. A batch completes on the pin side when the push side has accepted a threshold's worth of words, and this adds one pending request. A batch completes on the DMA side when the DMA side has taken a threshold's worth of words, and this removes one pending request. The request output is high while any request is pending. Because of this, a pin-side batch and a DMA-side batch that complete at nearly the same moment cannot cancel each other and drop a request. Pushes into a full store and pops from an empty store are reported through sticky flags. Software clears these flags by writing a one to the matching clear bit.

Top module: `rx_evt_fifo`

## Requirements
- R1: The store holds up to 64 words and returns them in the order they were accepted. The word from an accepted pop appears on `pop_data` at the clock edge that follows the pop, and `pop_data` holds its value in cycles with no pop.
- R2: The effective batch size comes from `thr_cfg`. A value of 0 is used as 1, any value above 32 is used as 32, and values from 1 to 32 are used unchanged.
- R3: The accepted push that completes a pin-side batch makes `dma_evt` high at the same clock edge that stores the word.
- R4: `dma_evt` stays high while at least one batch is pending. The accepted pop that completes a DMA-side batch removes one pending batch, and `dma_evt` falls at that edge when no batch remains.
- R5: When a pin-side batch and a DMA-side batch complete in the same cycle, or within a few cycles of each other, the pending count is unchanged and `dma_evt` stays high. Several pin-side batches that complete before any are drained each keep a request pending.
- R6: A push while the store holds 64 words is discarded and does not count toward a batch. It sets `ovf_flag`, which stays set until cleared.
- R7: A pop while the store is empty makes `pop_data` zero at the next edge and does not count toward a batch. It sets `udf_flag`, which stays set until cleared.
- R8: Bit 0 of `flag_clr` clears `ovf_flag` and bit 1 clears `udf_flag`. When a new error happens in the same cycle as a clear, the flag stays set.
- R9: Synchronous active-high reset empties the store, zeroes both batch counters and the pending count, drives `dma_evt`, both flags and `pop_data` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push_valid | input | 1 | Pin side presents a word this cycle |
| push_data | input | 32 | Word from the pin side |
| pop_req | input | 1 | DMA side takes a word this cycle |
| pop_data | output | 32 | Popped word, valid the cycle after the pop |
| thr_cfg | input | 8 | Batch size in words |
| flag_clr | input | 2 | Clear bits: bit 0 overflow, bit 1 underflow |
| dma_evt | output | 1 | Level DMA request, high while a batch is pending |
| ovf_flag | output | 1 | Sticky: a push was dropped because the store was full |
| udf_flag | output | 1 | Sticky: a pop was made on an empty store |

## Verification
The two functions that can fall in the same cycle are the pin side completing a batch and the DMA side completing a batch. This is the case that used to drop requests. The bench forces it directly: with a batch of four, it pushes one batch, then pushes and pops together so that both counters reach their batch boundary on the same edge, and it checks that the request stays high. Random traffic with independent push and pop rates then lands both completions on the same edge or on neighbouring edges many times. A bench model that counts pending batches judges the request level, the popped data and the flags every cycle.

// File: rtl/rx_evt_pkg.sv
package rx_evt_pkg;
  localparam int FLAG_OVF = 0;
  localparam int FLAG_UDF = 1;

  typedef struct packed {
    logic udf;
    logic ovf;
  } err_flags_t;
endpackage

// File: rtl/rx_evt_store.sv
module rx_evt_store #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             push_ok,
  output logic             pop_ok,
  output logic             push_drop,
  output logic             pop_miss
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    fill;

  always_comb begin
    push_ok   = push && (fill != FULL_CNT);
    pop_ok    = pop && (fill != '0);
    push_drop = push && !push_ok;
    pop_miss  = pop && !pop_ok;
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (pop_ok) begin
      rdata <= mem[rptr];
    end else if (pop_miss) begin
      rdata <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (pop_ok)  rptr <= rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
    fill <= FULL_CNT); // R1
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (push && fill == FULL_CNT) |=> fill == $past(fill) - CW'($past(pop))); // R6
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
    (pop && fill == '0) |=> rdata == '0); // R7
endmodule

// File: rtl/rx_evt_batch.sv
module rx_evt_batch #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic [TW-1:0] thr,
  output logic          done
);
  logic [TW-1:0] cnt;

  always_comb done = step && (({1'b0, cnt} + 1'b1) >= {1'b0, thr});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= done ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rx_evt_track.sv
module rx_evt_track #(
  parameter int PW = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic set_b,
  input  logic clr_b,
  output logic evt
);
  logic [PW-1:0] pend, pend_nxt;

  always_comb begin
    case ({set_b, clr_b})
      2'b10:   pend_nxt = pend + 1'b1;
      2'b01:   pend_nxt = pend - 1'b1;
      default: pend_nxt = pend;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      evt  <= 1'b0;
    end else begin
      pend <= pend_nxt;
      evt  <= (pend_nxt != '0);
    end
  end

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (rst)
    set_b |=> evt); // R3
  AST_LAST_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (clr_b && !set_b && pend == PW'(1)) |=> !evt); // R4
  AST_COLLIDE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (set_b && clr_b) |=> evt); // R5
endmodule

// File: rtl/rx_evt_fifo.sv
module rx_evt_fifo #(
  parameter int DEPTH   = 64,
  parameter int WIDTH   = 32,
  parameter int CFG_W   = 8,
  parameter int MAX_THR = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_valid,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop_req,
  output logic [WIDTH-1:0] pop_data,
  input  logic [CFG_W-1:0] thr_cfg,
  input  logic [1:0]       flag_clr,
  output logic             dma_evt,
  output logic             ovf_flag,
  output logic             udf_flag
);
  import rx_evt_pkg::*;

  localparam int TW = $clog2(MAX_THR + 1);
  localparam int PW = $clog2(DEPTH + 1);

  logic          push_ok, pop_ok, push_drop, pop_miss;
  logic          set_b, clr_b;
  logic [TW-1:0] thr_eff;
  err_flags_t    flg;

  always_comb begin
    if (thr_cfg == '0)
      thr_eff = TW'(1);
    else if (thr_cfg > CFG_W'(MAX_THR))
      thr_eff = TW'(MAX_THR);
    else
      thr_eff = TW'(thr_cfg);
  end

  rx_evt_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk(clk), .rst(rst), .push(push_valid), .wdata(push_data),
    .pop(pop_req), .rdata(pop_data), .push_ok(push_ok), .pop_ok(pop_ok),
    .push_drop(push_drop), .pop_miss(pop_miss)
  );

  rx_evt_batch #(.TW(TW)) u_pin_batch (
    .clk(clk), .rst(rst), .step(push_ok), .thr(thr_eff), .done(set_b)
  );

  rx_evt_batch #(.TW(TW)) u_dma_batch (
    .clk(clk), .rst(rst), .step(pop_ok), .thr(thr_eff), .done(clr_b)
  );

  rx_evt_track #(.PW(PW)) u_track (
    .clk(clk), .rst(rst), .set_b(set_b), .clr_b(clr_b), .evt(dma_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flg <= '0;
    end else begin
      flg.ovf <= push_drop || (flg.ovf && !flag_clr[FLAG_OVF]);
      flg.udf <= pop_miss  || (flg.udf && !flag_clr[FLAG_UDF]);
    end
  end

  assign ovf_flag = flg.ovf;
  assign udf_flag = flg.udf;

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !flag_clr[FLAG_OVF]) |=> ovf_flag); // R6
  AST_UDF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (udf_flag && !flag_clr[FLAG_UDF]) |=> udf_flag); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (push_drop && flag_clr[FLAG_OVF]) |=> ovf_flag); // R8
endmodule

// File: tb/test_rx_evt_fifo.sv
module test_rx_evt_fifo;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_valid = 1'b0;
  logic [31:0] push_data = '0;
  logic        pop_req = 1'b0;
  logic [31:0] pop_data;
  logic [7:0]  thr_cfg = 8'd4;
  logic [1:0]  flag_clr = '0;
  logic        dma_evt, ovf_flag, udf_flag;

  int checks = 0;
  int fails  = 0;

  logic [31:0] mq[$];
  int          pend, pcnt, ccnt;
  logic [31:0] exp_data;
  logic        exp_ovf, exp_udf;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_evt_fifo i_rx_evt_fifo (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
    .pop_req(pop_req), .pop_data(pop_data), .thr_cfg(thr_cfg),
    .flag_clr(flag_clr), .dma_evt(dma_evt), .ovf_flag(ovf_flag),
    .udf_flag(udf_flag)
  );

  function automatic int eff_thr(logic [7:0] raw);
    if (raw == 0) return 1;
    if (raw > 32) return 32;
    return int'(raw);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic [7:0] thr);
    @(negedge clk);
    rst = 1'b1; thr_cfg = thr; push_valid = 0; pop_req = 0; flag_clr = 0;
    @(negedge clk);
    rst = 1'b0;
    mq.delete(); pend = 0; pcnt = 0; ccnt = 0;
    exp_data = '0; exp_ovf = 0; exp_udf = 0;
    check("R9 evt", {31'b0, dma_evt}, 32'd0);
    check("R9 ovf", {31'b0, ovf_flag}, 32'd0);
    check("R9 udf", {31'b0, udf_flag}, 32'd0);
    check("R9 data", pop_data, 32'd0);
  endtask

  // one cycle: drive at negedge, model the edge, compare after it
  task automatic step(logic ps, logic pp, logic [31:0] d, logic [1:0] clr);
    int t, sz;
    logic pacc, cacc, setb, clrb;
    string etag;
    @(negedge clk);
    push_valid = ps; pop_req = pp; push_data = d; flag_clr = clr;
    @(posedge clk);
    #1;
    t = eff_thr(thr_cfg);
    sz = mq.size();
    pacc = ps && sz < 64;
    cacc = pp && sz > 0;
    if (cacc) exp_data = mq.pop_front();
    else if (pp) exp_data = '0;
    if (pacc) mq.push_back(d);
    setb = 0; clrb = 0;
    if (pacc) begin
      if (pcnt + 1 >= t) begin pcnt = 0; setb = 1; end else pcnt++;
    end
    if (cacc) begin
      if (ccnt + 1 >= t) begin ccnt = 0; clrb = 1; end else ccnt++;
    end
    pend = pend + int'(setb) - int'(clrb);
    exp_ovf = (ps && !pacc) || (exp_ovf && !clr[0]);
    exp_udf = (pp && !cacc) || (exp_udf && !clr[1]);
    etag = (setb && clrb) ? "R5 evt" : (setb ? "R3 evt" : "R4 evt");
    check(etag, {31'b0, dma_evt}, {31'b0, pend != 0});
    check(pp ? (cacc ? "R1 data" : "R7 data") : "R1 hold", pop_data, exp_data);
    check(clr[0] ? "R8 ovf" : "R6 ovf", {31'b0, ovf_flag}, {31'b0, exp_ovf});
    check(clr[1] ? "R8 udf" : "R7 udf", {31'b0, udf_flag}, {31'b0, exp_udf});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1357);
    // R2: zero threshold behaves as one
    do_reset(8'd0);
    step(1, 0, 32'h11, 0);
    check("R2 thr0", {31'b0, dma_evt}, 32'd1);
    // R2: oversize threshold clamps to 32
    do_reset(8'd40);
    for (int i = 0; i < 31; i++) step(1, 0, 32'h100 + i, 0);
    check("R2 thr40 early", {31'b0, dma_evt}, 32'd0);
    step(1, 0, 32'h200, 0);
    check("R2 thr40 at32", {31'b0, dma_evt}, 32'd1);
    // R5: both batches complete on the same edge
    do_reset(8'd4);
    for (int i = 0; i < 4; i++) step(1, 0, 32'hA0 + i, 0);
    for (int i = 0; i < 3; i++) step(1, 1, 32'hB0 + i, 0);
    step(1, 1, 32'hB3, 0);
    check("R5 same edge", {31'b0, dma_evt}, 32'd1);
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0);
    check("R4 drained", {31'b0, dma_evt}, 32'd0);
    // R5: back-to-back pending batches
    for (int i = 0; i < 8; i++) step(1, 0, 32'hC0 + i, 0);
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0);
    check("R5 second pending", {31'b0, dma_evt}, 32'd1);
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0);
    check("R4 all drained", {31'b0, dma_evt}, 32'd0);
    // R7 underflow, R8 clear with set winning
    step(0, 1, 0, 0);
    check("R7 udf set", {31'b0, udf_flag}, 32'd1);
    step(0, 1, 0, 2'b10);
    check("R8 set wins", {31'b0, udf_flag}, 32'd1);
    step(0, 0, 0, 2'b10);
    check("R8 cleared", {31'b0, udf_flag}, 32'd0);
    // R6 overflow: fill past 64 words
    for (int i = 0; i < 66; i++) step(1, 0, 32'hD00 + i, 0);
    check("R6 ovf set", {31'b0, ovf_flag}, 32'd1);
    step(0, 0, 0, 2'b01);
    check("R8 ovf cleared", {31'b0, ovf_flag}, 32'd0);
    for (int i = 0; i < 64; i++) step(0, 1, 0, 0);
    check("R6 last kept word", pop_data, 32'hD3F);
    // random rounds
    for (int r = 0; r < 8; r++) begin
      int pp_rate, pc_rate;
      do_reset(8'($urandom_range(1, 36)));
      pp_rate = $urandom_range(20, 80);
      pc_rate = $urandom_range(20, 80);
      for (int c = 0; c < 500; c++)
        step($urandom_range(0, 99) < pp_rate, $urandom_range(0, 99) < pc_rate,
             $urandom, ($urandom_range(0, 19) == 0) ? 2'($urandom) : 2'b00);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule